// File: doc/BRIEF.md
# Two-Register Multiplexed Arithmetic Datapath

This block is a small register-transfer datapath for use under an external controller that issues one control word per clock. It holds two data registers: an operand register that is preset from its own load port, and an accumulator register whose next value is chosen by a two-bit operation code. Two single-bit selectors each pick an operand for the arithmetic units, either the operand register or the external data input. A two-bit result selector then picks one of four sources for the result bus: the sum of the first operand and the accumulator, the external data input, the operand register, or the product of the second operand and the accumulator.

The result bus is combinational and visible at the ports in the same cycle as the control word. The accumulator can be cleared, held or loaded from the result bus on the next rising clock edge. Sums and products are truncated to the data width. A synchronous active-high reset clears both registers. A parameter chooses how the multiplier is built: either a behavioural product or an unrolled shift-and-add array. Both forms give the same truncated result.

Top module: `rtdp_datapath`

## Requirements
- R1: With `sel_a` = 0 the first operand is the operand register; with `sel_a` = 1 it is `din`. This is observed on `res_out` when `sel_res` = 0.
- R2: With `sel_b` = 0 the second operand is the operand register; with `sel_b` = 1 it is `din`. This is observed on `res_out` when `sel_res` = 3.
- R3: `res_out` is combinational from the current inputs and registers. `sel_res` code 0 gives (first operand + accumulator) mod 2^DATA_W. Code 1 gives `din`. Code 2 gives the operand register. Code 3 gives (second operand × accumulator) mod 2^DATA_W.
- R4: `acc_op` code 0 clears the accumulator to zero at the next rising edge.
- R5: `acc_op` codes 1 and 3 leave the accumulator unchanged at the next rising edge.
- R6: `acc_op` code 2 loads the accumulator at the next rising edge with the value `res_out` had before that edge.
- R7: When `opnd_we` is 1, the operand register takes `opnd_wdata` at the next rising edge. When `opnd_we` is 0, the operand register keeps its value. It is seen through `sel_res` = 2.
- R8: While `rst` is 1 at a rising edge, both registers become zero. This overrides `opnd_we` and `acc_op`.
- R9: With `sel_b` = 0, `sel_res` = 3 and `acc_op` = 2, the accumulator becomes (operand register × accumulator) mod 2^DATA_W after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of both registers |
| opnd_we | input | 1 | Load enable of the operand register |
| opnd_wdata | input | DATA_W | Value loaded into the operand register |
| sel_a | input | 1 | First operand select (0 register, 1 din) |
| sel_b | input | 1 | Second operand select (0 register, 1 din) |
| sel_res | input | 2 | Result source select (0 sum, 1 din, 2 register, 3 product) |
| acc_op | input | 2 | Accumulator operation (0 clear, 1 hold, 2 load, 3 hold) |
| din | input | DATA_W | External data input |
| acc_q | output | DATA_W | Accumulator register value |
| res_out | output | DATA_W | Result bus |

## Verification
A corrupted accumulator shows on `acc_q` right away. It also shows on `res_out` in the same cycle through the sum and product codes. A corrupted operand register is hidden until `sel_res` = 2 or until an operand select picks it. So the random control words go through those codes often enough that a bad value appears within a few cycles. A wrong selector decode shows at once on `res_out`. A wrong accumulator operation shows one edge later on `acc_q`.

// File: rtl/rtdp_pkg.sv
package rtdp_pkg;
   typedef enum logic [0:0] {
      OPND_FROM_REG = 1'b0,
      OPND_FROM_DIN = 1'b1
   } opnd_sel_e;

   typedef enum logic [1:0] {
      RES_SUM  = 2'd0,
      RES_DIN  = 2'd1,
      RES_REG  = 2'd2,
      RES_PROD = 2'd3
   } res_sel_e;

   typedef enum logic [1:0] {
      ACC_CLEAR = 2'd0,
      ACC_HOLD  = 2'd1,
      ACC_LOAD  = 2'd2,
      ACC_KEEP  = 2'd3
   } acc_op_e;
endpackage

// File: rtl/rtdp_opnd_mux.sv
module rtdp_opnd_mux #(
   parameter int DATA_W = 8
) (
   input  logic              sel,
   input  logic [DATA_W-1:0] reg_val,
   input  logic [DATA_W-1:0] ext_val,
   output logic [DATA_W-1:0] opnd
);
   import rtdp_pkg::*;

   opnd_sel_e sel_e;

   always_comb begin
      sel_e = opnd_sel_e'(sel);
      unique case (sel_e)
         OPND_FROM_REG: opnd = reg_val;
         OPND_FROM_DIN: opnd = ext_val;
         default:       opnd = reg_val;
      endcase
   end
endmodule

// File: rtl/rtdp_multiplier.sv
module rtdp_multiplier #(
   parameter int DATA_W    = 8,
   parameter bit SHIFT_ADD = 1'b0
) (
   input  logic [DATA_W-1:0] mcand,
   input  logic [DATA_W-1:0] mplier,
   output logic [DATA_W-1:0] prod
);
   generate
      if (SHIFT_ADD) begin : g_array
         logic [DATA_W-1:0] partial [DATA_W+1];
         assign partial[0] = '0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_row
            logic [DATA_W-1:0] term;
            assign term          = mplier[i] ? (mcand << i) : '0;
            assign partial[i+1]  = partial[i] + term;
         end
         assign prod = partial[DATA_W];
      end else begin : g_behav
         logic [2*DATA_W-1:0] full;
         assign full = {{DATA_W{1'b0}}, mcand} * {{DATA_W{1'b0}}, mplier};
         assign prod = full[DATA_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/rtdp_result_mux.sv
module rtdp_result_mux #(
   parameter int DATA_W        = 8,
   parameter bit MUL_SHIFT_ADD = 1'b0
) (
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] reg_val,
   input  logic [DATA_W-1:0] acc_val,
   input  logic [DATA_W-1:0] ext_val,
   output logic [DATA_W-1:0] result
);
   import rtdp_pkg::*;

   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] prod;
   res_sel_e          sel_e;

   assign sum = opnd_a + acc_val;

   rtdp_multiplier #(
      .DATA_W    (DATA_W),
      .SHIFT_ADD (MUL_SHIFT_ADD)
   ) u_mul (
      .mcand  (opnd_b),
      .mplier (acc_val),
      .prod   (prod)
   );

   always_comb begin
      sel_e = res_sel_e'(sel);
      unique case (sel_e)
         RES_SUM:  result = sum;
         RES_DIN:  result = ext_val;
         RES_REG:  result = reg_val;
         RES_PROD: result = prod;
         default:  result = sum;
      endcase
   end
endmodule

// File: rtl/rtdp_acc_reg.sv
module rtdp_acc_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   import rtdp_pkg::*;

   acc_op_e           op_e;
   logic [DATA_W-1:0] q_next;

   always_comb begin
      op_e = acc_op_e'(op);
      unique case (op_e)
         ACC_CLEAR: q_next = '0;
         ACC_LOAD:  q_next = d;
         ACC_HOLD,
         ACC_KEEP:  q_next = q;
         default:   q_next = q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= q_next;
   end
endmodule

// File: rtl/rtdp_datapath.sv
module rtdp_datapath #(
   parameter int DATA_W        = 8,
   parameter bit MUL_SHIFT_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              opnd_we,
   input  logic [DATA_W-1:0] opnd_wdata,
   input  logic              sel_a,
   input  logic              sel_b,
   input  logic [1:0]        sel_res,
   input  logic [1:0]        acc_op,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] acc_q,
   output logic [DATA_W-1:0] res_out
);
   localparam int MAX_W = 64;

   generate
      if (DATA_W < 1 || DATA_W > MAX_W) begin : g_bad_width
         $error("rtdp_datapath: DATA_W out of range");
      end
   endgenerate

   logic [DATA_W-1:0] opnd_q;
   logic [DATA_W-1:0] opnd_a;
   logic [DATA_W-1:0] opnd_b;

   always_ff @(posedge clk) begin
      if (rst)          opnd_q <= '0;
      else if (opnd_we) opnd_q <= opnd_wdata;
   end

   rtdp_opnd_mux #(.DATA_W(DATA_W)) u_mux_a (
      .sel     (sel_a),
      .reg_val (opnd_q),
      .ext_val (din),
      .opnd    (opnd_a)
   );

   rtdp_opnd_mux #(.DATA_W(DATA_W)) u_mux_b (
      .sel     (sel_b),
      .reg_val (opnd_q),
      .ext_val (din),
      .opnd    (opnd_b)
   );

   rtdp_result_mux #(
      .DATA_W        (DATA_W),
      .MUL_SHIFT_ADD (MUL_SHIFT_ADD)
   ) u_res (
      .sel     (sel_res),
      .opnd_a  (opnd_a),
      .opnd_b  (opnd_b),
      .reg_val (opnd_q),
      .acc_val (acc_q),
      .ext_val (din),
      .result  (res_out)
   );

   rtdp_acc_reg #(.DATA_W(DATA_W)) u_acc (
      .clk (clk),
      .rst (rst),
      .op  (acc_op),
      .d   (res_out),
      .q   (acc_q)
   );
endmodule

// File: rtl/rtdp_datapath_chk.sv
module rtdp_datapath_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              opnd_we,
   input logic [DATA_W-1:0] opnd_wdata,
   input logic [1:0]        sel_res,
   input logic [1:0]        acc_op,
   input logic [DATA_W-1:0] din,
   input logic [DATA_W-1:0] acc_q,
   input logic [DATA_W-1:0] res_out,
   input logic [DATA_W-1:0] opnd_q
);
   AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (acc_op == 2'd0) |=> (acc_q == '0));  // R4
   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
      (acc_op == 2'd1 || acc_op == 2'd3) |=> $stable(acc_q));  // R5
   AST_ACC_LOAD: assert property (@(posedge clk) disable iff (rst)
      (acc_op == 2'd2) |=> (acc_q == $past(res_out)));  // R6
   AST_RES_DIN: assert property (@(posedge clk) disable iff (rst)
      (sel_res == 2'd1) |-> (res_out == din));  // R3
   AST_RES_REG: assert property (@(posedge clk) disable iff (rst)
      (sel_res == 2'd2) |-> (res_out == opnd_q));  // R3
   AST_OPND_LOAD: assert property (@(posedge clk) disable iff (rst)
      opnd_we |=> (opnd_q == $past(opnd_wdata)));  // R7
   AST_OPND_HOLD: assert property (@(posedge clk) disable iff (rst)
      !opnd_we |=> $stable(opnd_q));  // R7
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (acc_q == '0 && opnd_q == '0));  // R8
endmodule

bind rtdp_datapath rtdp_datapath_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .opnd_we    (opnd_we),
   .opnd_wdata (opnd_wdata),
   .sel_res    (sel_res),
   .acc_op     (acc_op),
   .din        (din),
   .acc_q      (acc_q),
   .res_out    (res_out),
   .opnd_q     (opnd_q)
);

// File: tb/rtdp_datapath_bench.sv
`timescale 1ns/1ps
module rtdp_datapath_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst;
   logic         opnd_we;
   logic [W-1:0] opnd_wdata;
   logic         sel_a;
   logic         sel_b;
   logic [1:0]   sel_res;
   logic [1:0]   acc_op;
   logic [W-1:0] din;
   logic [W-1:0] acc_q;
   logic [W-1:0] res_out;

   int checks   = 0;
   int failures = 0;
   logic [W-1:0] m_reg = '0;
   logic [W-1:0] m_acc = '0;

   always #2.5 clk = ~clk;

   rtdp_datapath #(.DATA_W(W)) u_rtdp_datapath (
      .clk(clk), .rst(rst), .opnd_we(opnd_we), .opnd_wdata(opnd_wdata),
      .sel_a(sel_a), .sel_b(sel_b), .sel_res(sel_res), .acc_op(acc_op),
      .din(din), .acc_q(acc_q), .res_out(res_out)
   );

   function automatic logic [W-1:0] exp_res(input logic a, input logic b,
         input logic [1:0] s, input logic [W-1:0] d,
         input logic [W-1:0] r, input logic [W-1:0] acc);
      logic [W-1:0] oa = a ? d : r;
      logic [W-1:0] ob = b ? d : r;
      logic [2*W-1:0] p = {{W{1'b0}}, ob} * {{W{1'b0}}, acc};
      case (s)
         2'd0:    return oa + acc;
         2'd1:    return d;
         2'd2:    return r;
         default: return p[W-1:0];
      endcase
   endfunction

   task automatic check(input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic we, input logic [W-1:0] wd,
                       input logic a, input logic b, input logic [1:0] s,
                       input logic [1:0] op, input logic [W-1:0] d);
      logic [W-1:0] e_res;
      string tag_res;
      string tag_acc;
      @(negedge clk);
      rst = r; opnd_we = we; opnd_wdata = wd; sel_a = a; sel_b = b;
      sel_res = s; acc_op = op; din = d;
      #1;
      e_res = exp_res(a, b, s, d, m_reg, m_acc);
      case (s)
         2'd0:    tag_res = "R1 R3 sum";
         2'd1:    tag_res = "R3 din";
         2'd2:    tag_res = "R7 R3 register";
         default: tag_res = "R2 R3 product";
      endcase
      check(tag_res, res_out, e_res);
      if (r) begin
         m_reg = '0; m_acc = '0; tag_acc = "R8 reset";
      end else begin
         if (we) m_reg = wd;
         case (op)
            2'd0: begin m_acc = '0;    tag_acc = "R4 clear"; end
            2'd2: begin m_acc = e_res; tag_acc = (s == 2'd3 && !b) ? "R9 R6 mul-load" : "R6 load"; end
            default: tag_acc = "R5 hold";
         endcase
      end
      @(posedge clk);
      #1;
      check(tag_acc, acc_q, m_acc);
   endtask

   initial begin
      #(5.0 * 20000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst = 1'b1; opnd_we = 1'b1; opnd_wdata = 8'h5A; sel_a = 0; sel_b = 0;
      sel_res = 2'd2; acc_op = 2'd2; din = 8'h33;
      @(posedge clk); @(posedge clk);
      // R8: reset wins over load enables
      step(1'b1, 1'b1, 8'hA5, 0, 0, 2'd1, 2'd2, 8'h77);
      step(1'b0, 1'b0, 8'h00, 0, 0, 2'd2, 2'd1, 8'h00);
      check("R8 register after reset", res_out, 8'h00);
      // directed: preset operand, load acc from din, multiply-accumulate
      step(1'b0, 1'b1, 8'h0D, 0, 0, 2'd1, 2'd2, 8'h07);
      step(1'b0, 1'b0, 8'h00, 0, 0, 2'd3, 2'd2, 8'h00);   // R9: 0x0D*7
      check("R9 product stored", acc_q, 8'h5B);
      step(1'b0, 1'b0, 8'h00, 1, 0, 2'd0, 2'd2, 8'hFF);   // R3 wrap 0xFF+0x5B
      check("R3 sum truncated", acc_q, 8'h5A);
      step(1'b0, 1'b1, 8'hFF, 0, 1, 2'd3, 2'd3, 8'h10);   // R5 code 3 holds
      step(1'b0, 1'b0, 8'h00, 0, 0, 2'd3, 2'd2, 8'h00);   // R9 wrap 0xFF*0x5A
      step(1'b0, 1'b0, 8'h00, 0, 1, 2'd2, 2'd0, 8'h00);   // R4 clear
      step(1'b0, 1'b0, 8'h00, 0, 0, 2'd3, 2'd1, 8'h00);   // product with zero acc
      for (int i = 0; i < 600; i++) begin
         logic [31:0] rv = $urandom;
         step(rv[31:26] == 6'd0, rv[0], W'($urandom), rv[1], rv[2],
              rv[4:3], rv[6:5], W'($urandom));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule